// File: doc/BRIEF.md
# Memory Fence Ordering Unit

This block sits between an in-order request source and a memory system that keeps several requests in flight and may finish them in any order. Loads and stores go straight through to memory in the same cycle they are offered. The block gives each one a slot tag and records its class: load or store, and whether its address lies inside a configured region. Outside of fences nothing is held back, so completions may come back in any order.

A fence request never reaches memory. It arms a single pending-fence register with one of four scopes: everything, loads only, stores only, or the region. Each class has an outstanding counter. While the fence is pending, a later request that the scope covers is stalled at the request port. A request the scope does not cover keeps flowing past it. The fence is done in the first cycle that the counters for its scope all read zero, and `fence_done` pulses in that cycle.

The request port is valid/ready. The source must hold a request stable while `req_valid` is high and `req_ready` is low. A load or store is accepted only in a cycle where both `mem_valid` and `mem_ready` are high. Completions arrive as a one-cycle `cpl_valid` pulse carrying the tag that was issued.

Top module: `mem_fence_unit`

## Requirements
- R1: After reset no fence is pending, every slot is free, `fence_done` and `mem_valid` are low, and with `mem_ready` high a load or store would be accepted.
- R2: With no fence pending and a free slot, an offered load (`req_fence`=0, `req_store`=0) or store (`req_store`=1) drives `mem_valid` in the same cycle, with `mem_addr` equal to `req_addr` and `mem_is_store` equal to `req_store`.
- R3: For loads and stores, `req_ready` is low whenever `mem_ready` is low, so a request is accepted only when memory takes it.
- R4: When MAX_OUT requests are outstanding, `mem_valid` and `req_ready` stay low for loads and stores until a completion frees a slot.
- R5: The tag issued with a request is the lowest-numbered slot not currently outstanding. A completion frees its slot from the next cycle on.
- R6: A fence with scope 0 (all) stalls every later load and store while it is pending. `fence_done` rises in the first cycle in which no earlier load or store is outstanding.
- R7: A fence with scope 1 (loads) waits only for outstanding loads and stalls only later loads; stores issue past it.
- R8: A fence with scope 2 (stores) waits only for outstanding stores and stalls only later stores; loads issue past it.
- R9: A fence with scope 3 (region) waits only for outstanding requests whose address satisfies `region_base` <= addr <= `region_limit`, and stalls only such requests.
- R10: A fence accepted while nothing it covers is outstanding raises `fence_done` in the very next cycle, for exactly one cycle.
- R11: A fence never drives `mem_valid`. While a fence is pending, `req_ready` is low for a new fence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_base | input | ADDR_W | Lowest address of the ordered region (inclusive) |
| region_limit | input | ADDR_W | Highest address of the ordered region (inclusive) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid is high |
| req_fence | input | 1 | 1: request is a fence, 0: load or store |
| req_scope | input | 2 | Fence scope: 0 all, 1 loads, 2 stores, 3 region |
| req_store | input | 1 | For non-fence requests: 1 store, 0 load |
| req_addr | input | ADDR_W | Request address |
| mem_valid | output | 1 | Load or store presented to memory |
| mem_ready | input | 1 | Memory takes the presented request |
| mem_is_store | output | 1 | Presented request is a store |
| mem_addr | output | ADDR_W | Presented address |
| mem_tag | output | TAG_W | Slot tag for the presented request |
| cpl_valid | input | 1 | Completion pulse from memory |
| cpl_tag | input | TAG_W | Tag of the completing request |
| fence_done | output | 1 | Pending fence satisfied this cycle |

## Verification
The bench aims first at fences that land while their covered class is already empty. A design that waited one cycle too long, or that never freed its fence register, would show a late or repeated `fence_done`. It also aims at requests outside a fence's scope that arrive while the fence is pending. A unit that treated every fence as a full barrier would stall those requests, while one that ignored the scope would let covered requests slip past. The bench fills every slot with completions held off, so a wrong limit either issues a ninth request or reuses a tag still in flight. Random traffic also places completions in the same cycle as new issues and right at region boundaries. A counter that dropped a simultaneous increment and decrement, or used an exclusive bound, would release a fence early or hold it forever.

// File: rtl/mfu_pkg.sv
package mfu_pkg;

  typedef enum logic [1:0] {
    FS_ALL    = 2'd0,
    FS_LOADS  = 2'd1,
    FS_STORES = 2'd2,
    FS_REGION = 2'd3
  } fence_scope_e;

  typedef struct packed {
    logic is_store;
    logic in_rgn;
  } op_class_t;

  localparam int CLS_LD  = 0;
  localparam int CLS_ST  = 1;
  localparam int CLS_RG  = 2;
  localparam int NUM_CLS = 3;

endpackage

// File: rtl/mfu_slot_table.sv
module mfu_slot_table
  import mfu_pkg::*;
#(
  parameter int MAX_OUT = 8,
  localparam int TAG_W  = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  op_class_t        alloc_cls,
  input  logic             free_en,
  input  logic [TAG_W-1:0] free_tag,
  output logic [TAG_W-1:0] alloc_tag,
  output logic             full,
  output op_class_t        free_cls
);

  logic [MAX_OUT-1:0] occ_q;
  op_class_t          cls_q [MAX_OUT];

  // lowest free slot: scan from the top so the smallest index wins
  always_comb begin
    logic found;
    found     = 1'b0;
    alloc_tag = '0;
    for (int i = MAX_OUT - 1; i >= 0; i--) begin
      if (!occ_q[i]) begin
        found     = 1'b1;
        alloc_tag = TAG_W'(i);
      end
    end
    full = !found;
  end

  always_comb begin
    free_cls = '0;
    for (int i = 0; i < MAX_OUT; i++) begin
      if (free_tag == TAG_W'(i)) free_cls = cls_q[i];
    end
  end

  for (genvar g = 0; g < MAX_OUT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ_q[g] <= 1'b0;
        cls_q[g] <= '0;
      end else if (alloc_en && alloc_tag == TAG_W'(g)) begin
        occ_q[g] <= 1'b1;
        cls_q[g] <= alloc_cls;
      end else if (free_en && free_tag == TAG_W'(g)) begin
        occ_q[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mfu_class_counter.sv
module mfu_class_counter #(
  parameter int MAX_OUT = 8,
  localparam int CW     = $clog2(MAX_OUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (inc && !dec) cnt_q <= cnt_q + CW'(1);
    else if (dec && !inc) cnt_q <= cnt_q - CW'(1);
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/mfu_fence_ctrl.sv
module mfu_fence_ctrl
  import mfu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fence_acc,
  input  logic [1:0]         fence_scope,
  input  logic [NUM_CLS-1:0] cls_zero,
  input  logic               op_store,
  input  logic               op_in_rgn,
  output logic               pending,
  output logic               done,
  output logic               op_stall
);

  fence_scope_e scope_q;
  logic         pend_q;
  logic         covered;
  logic         drained;

  always_comb begin
    unique case (scope_q)
      FS_ALL:    begin covered = 1'b1;      drained = cls_zero[CLS_LD] && cls_zero[CLS_ST]; end
      FS_LOADS:  begin covered = !op_store; drained = cls_zero[CLS_LD]; end
      FS_STORES: begin covered = op_store;  drained = cls_zero[CLS_ST]; end
      default:   begin covered = op_in_rgn; drained = cls_zero[CLS_RG]; end
    endcase
  end

  assign pending  = pend_q;
  assign done     = pend_q && drained;
  assign op_stall = pend_q && covered;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      scope_q <= FS_ALL;
    end else if (done) begin
      pend_q  <= 1'b0;
    end else if (fence_acc) begin
      pend_q  <= 1'b1;
      scope_q <= fence_scope_e'(fence_scope);
    end
  end

endmodule

// File: rtl/mem_fence_unit.sv
module mem_fence_unit
  import mfu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_OUT = 8,
  localparam int TAG_W  = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] region_base,
  input  logic [ADDR_W-1:0] region_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_fence,
  input  logic [1:0]        req_scope,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_is_store,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [TAG_W-1:0]  mem_tag,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  output logic              fence_done
);

  logic               in_rgn;
  logic               full;
  logic               fpend;
  logic               op_stall;
  logic               issue_ok;
  logic               op_acc;
  logic               fence_acc;
  logic [TAG_W-1:0]   alloc_tag;
  op_class_t          new_cls;
  op_class_t          done_cls;
  logic [NUM_CLS-1:0] cls_inc;
  logic [NUM_CLS-1:0] cls_dec;
  logic [NUM_CLS-1:0] cls_zero;

  assign in_rgn   = (req_addr >= region_base) && (req_addr <= region_limit);
  assign issue_ok = !full && !op_stall;

  assign mem_valid    = req_valid && !req_fence && issue_ok;
  assign req_ready    = req_fence ? !fpend : (mem_ready && issue_ok);
  assign mem_is_store = req_store;
  assign mem_addr     = req_addr;
  assign mem_tag      = alloc_tag;

  assign op_acc    = mem_valid && mem_ready;
  assign fence_acc = req_valid && req_fence && !fpend;

  assign new_cls.is_store = req_store;
  assign new_cls.in_rgn   = in_rgn;

  assign cls_inc[CLS_LD] = op_acc && !req_store;
  assign cls_inc[CLS_ST] = op_acc && req_store;
  assign cls_inc[CLS_RG] = op_acc && in_rgn;
  assign cls_dec[CLS_LD] = cpl_valid && !done_cls.is_store;
  assign cls_dec[CLS_ST] = cpl_valid && done_cls.is_store;
  assign cls_dec[CLS_RG] = cpl_valid && done_cls.in_rgn;

  mfu_slot_table #(.MAX_OUT(MAX_OUT)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (op_acc),
    .alloc_cls (new_cls),
    .free_en   (cpl_valid),
    .free_tag  (cpl_tag),
    .alloc_tag (alloc_tag),
    .full      (full),
    .free_cls  (done_cls)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    mfu_class_counter #(.MAX_OUT(MAX_OUT)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cls_inc[c]),
      .dec   (cls_dec[c]),
      .zero  (cls_zero[c])
    );
  end

  mfu_fence_ctrl u_fence (
    .clk         (clk),
    .rst_n       (rst_n),
    .fence_acc   (fence_acc),
    .fence_scope (req_scope),
    .cls_zero    (cls_zero),
    .op_store    (req_store),
    .op_in_rgn   (in_rgn),
    .pending     (fpend),
    .done        (fence_done),
    .op_stall    (op_stall)
  );

endmodule

// File: rtl/mfu_checker.sv
module mfu_checker #(
  parameter int ADDR_W  = 16,
  parameter int MAX_OUT = 8,
  localparam int TAG_W  = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1,
  localparam int OW     = $clog2(MAX_OUT + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] region_base,
  input logic [ADDR_W-1:0] region_limit,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_fence,
  input logic [1:0]        req_scope,
  input logic              req_store,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_is_store,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [TAG_W-1:0]  mem_tag,
  input logic              cpl_valid,
  input logic [TAG_W-1:0]  cpl_tag,
  input logic              fence_done
);

  // independent in-flight count taken from the memory-side handshakes
  logic [OW-1:0] inflight;
  logic          issued;
  assign issued = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + OW'(issued) - OW'(cpl_valid);
  end

  p_fence_not_issued_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fence) |-> !mem_valid);

  p_fence_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fence && req_ready) |=> !(req_valid && req_fence && req_ready));

  p_ready_follows_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fence && !mem_ready) |-> !req_ready);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == OW'(MAX_OUT)) |-> !mem_valid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |=> !fence_done);

endmodule

bind mem_fence_unit mfu_checker #(.ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT)) u_chk (.*);

// File: tb/sim_mem_fence_unit.sv
`timescale 1ns/1ps
module sim_mem_fence_unit;

  localparam int AW   = 16;
  localparam int MAXO = 8;
  localparam int TW   = 3;
  localparam logic [AW-1:0] RBASE = 16'h0040;
  localparam logic [AW-1:0] RLIM  = 16'h007F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_fence = 0, req_store = 0, mem_ready = 0, cpl_valid = 0;
  logic [1:0]    req_scope = 0;
  logic [AW-1:0] req_addr = 0;
  logic [TW-1:0] cpl_tag = 0;
  logic          req_ready, mem_valid, mem_is_store, fence_done;
  logic [AW-1:0] mem_addr;
  logic [TW-1:0] mem_tag;

  mem_fence_unit #(.ADDR_W(AW), .MAX_OUT(MAXO)) u0 (
    .clk(clk), .rst_n(rst_n), .region_base(RBASE), .region_limit(RLIM),
    .req_valid(req_valid), .req_ready(req_ready), .req_fence(req_fence),
    .req_scope(req_scope), .req_store(req_store), .req_addr(req_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_is_store(mem_is_store),
    .mem_addr(mem_addr), .mem_tag(mem_tag), .cpl_valid(cpl_valid),
    .cpl_tag(cpl_tag), .fence_done(fence_done));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference state
  bit occ [MAXO];
  bit mst [MAXO];
  bit mrg [MAXO];
  int lat [MAXO];
  bit fpend = 0;
  int fscope = 0;

  // stimulus controls
  bit have = 0, gen_en = 0, hold_cpl = 0, force_ready = 0;
  int fence_pct = 12, max_lat = 12;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit in_region(logic [AW-1:0] a);
    return (a >= RBASE) && (a <= RLIM);
  endfunction

  function automatic string scope_tag(int s);
    case (s)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int low_free();
    for (int i = 0; i < MAXO; i++) if (!occ[i]) return i;
    return -1;
  endfunction

  function automatic bit covered(int s, bit st, bit rg);
    case (s)
      0: return 1;
      1: return !st;
      2: return st;
      default: return rg;
    endcase
  endfunction

  function automatic bit drained(int s);
    int nl = 0, ns = 0, nr = 0;
    for (int i = 0; i < MAXO; i++) if (occ[i]) begin
      if (mst[i]) ns++; else nl++;
      if (mrg[i]) nr++;
    end
    case (s)
      0: return nl == 0 && ns == 0;
      1: return nl == 0;
      2: return ns == 0;
      default: return nr == 0;
    endcase
  endfunction

  task automatic new_req();
    have      = 1;
    req_fence = ($urandom % 100) < fence_pct;
    req_scope = 2'($urandom % 4);
    req_store = 1'($urandom % 2);
    req_addr  = AW'($urandom % 256);
  endtask

  task automatic step();
    bit cv = 0;
    int ct = 0, lo;
    bit full, cov, edone, emv, erdy, inr;
    string tg;
    if (!hold_cpl)
      for (int i = 0; i < MAXO; i++)
        if (!cv && occ[i] && lat[i] == 0 && ($urandom % 4) != 0) begin cv = 1; ct = i; end
    cpl_valid = cv;
    cpl_tag   = TW'(ct);
    mem_ready = force_ready || (($urandom % 8) != 0);
    if (!have && gen_en && ($urandom % 4) != 0) new_req();
    req_valid = have;
    @(negedge clk);
    lo    = low_free();
    full  = (lo < 0);
    inr   = in_region(req_addr);
    cov   = fpend && covered(fscope, req_store, inr);
    edone = fpend && drained(fscope);
    emv   = req_valid && !req_fence && !full && !cov;
    erdy  = req_fence ? !fpend : (mem_ready && !full && !cov);
    if (req_valid && req_fence)      tg = "R11";
    else if (req_valid && fpend)     tg = scope_tag(fscope);
    else if (req_valid && full)      tg = "R4";
    else if (req_valid && !mem_ready) tg = "R3";
    else                             tg = "R2";
    chk(fence_done == edone, fpend ? scope_tag(fscope) : "R6", "fence_done", fence_done, edone);
    chk(mem_valid == emv, tg, "mem_valid", mem_valid, emv);
    if (req_valid) chk(req_ready == erdy, tg, "req_ready", req_ready, erdy);
    if (emv) begin
      chk(mem_tag == TW'(lo), "R5", "mem_tag", mem_tag, lo);
      chk(mem_addr == req_addr && mem_is_store == req_store, "R2", "mem_addr", mem_addr, req_addr);
    end
    for (int i = 0; i < MAXO; i++) if (lat[i] > 0) lat[i]--;
    if (cv) occ[ct] = 0;
    if (edone) fpend = 0;
    if (req_valid && erdy) begin
      if (req_fence) begin fpend = 1; fscope = int'(req_scope); end
      else begin
        occ[lo] = 1; mst[lo] = req_store; mrg[lo] = inr;
        lat[lo] = int'($urandom % (max_lat + 1));
      end
      have = 0;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic offer(bit f, logic [1:0] s, bit st, logic [AW-1:0] a);
    have = 1; req_fence = f; req_scope = s; req_store = st; req_addr = a;
  endtask

  initial begin
    #(4ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250426));
    for (int i = 0; i < MAXO; i++) begin occ[i] = 0; mst[i] = 0; mrg[i] = 0; lat[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    mem_ready = 1;
    // R1: idle state after reset
    @(negedge clk);
    chk(!mem_valid && !fence_done, "R1", "idle outputs", {mem_valid, fence_done}, 0);
    req_fence = 0;
    #0.1;
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
    @(posedge clk); #1;

    // R10: fence on an empty unit completes the next cycle
    force_ready = 1;
    offer(1, 2'd0, 0, 0);
    step();
    have = 0; req_valid = 0;
    @(negedge clk);
    chk(fence_done == 1, "R10", "fence_done empty", fence_done, 1);
    @(posedge clk); #1;
    fpend = 0;
    @(negedge clk);
    chk(fence_done == 0, "R10", "fence_done pulse", fence_done, 0);
    @(posedge clk); #1;

    // R4: fill every slot with completions held, then release
    hold_cpl = 1;
    for (int i = 0; i < MAXO + 3; i++) begin
      offer(0, 0, 1'(i % 2), AW'(i * 20));
      step();
      step();
    end
    hold_cpl = 0;
    repeat (60) step();

    // R7/R8/R9: a pending scoped fence with traffic of the other kind behind it
    for (int s = 1; s < 4; s++) begin
      hold_cpl = 1;
      offer(0, 0, (s == 1) ? 1'b0 : 1'b1, 16'h0050);
      step();
      offer(1, 2'(s), 0, 0);
      step();
      offer(0, 0, (s == 1) ? 1'b1 : 1'b0, 16'h00F0);
      step();
      step();
      hold_cpl = 0;
      repeat (40) step();
    end
    force_ready = 0;

    // R11 and general mix: random traffic with fences of every scope
    gen_en = 1;
    for (int k = 0; k < 4000; k++) begin
      if (k == 2000) begin fence_pct = 30; max_lat = 3; end
      step();
    end
    gen_en = 0;
    repeat (60) step();
    finish_run();
  end

endmodule